// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers event pulses from a fixed set of sources and decides when the processor must leave its normal flow. Each source latches a pending flag. Each source also has an enable bit and, except source 0, a level bit. When priority mode is on, the level bit sends the source to the high level or the low level. Each level has its own global enable and its own fixed target address: 0x0008 for high and 0x0018 for low. When priority mode is off, the block works in legacy mode. There is then one global enable, and sources at or above index `NUM_CORE` are also gated by a peripheral-group enable. Every interrupt in legacy mode goes to 0x0008.

When a request wins, the block sends a one-cycle take pulse with the target address. In the same cycle it clears the global enable of the level taken and saves three context bytes (status, working register, bank select) in shadow registers. A later fast return can read them back. The return-from-interrupt event ends the service in progress and sets that level's global enable again. The service is tracked by four states:
- `ST_IDLE`: nothing active.
- `ST_LO`: low-level service.
- `ST_HI`: high-level service with nothing beneath it.
- `ST_HI_OVER_LO`: high-level service that preempted a low-level one.

The state transitions are:
- idle to low, on a low take.
- idle to high, on a high take.
- low to high-over-low, on a high take (preemption).
- low to idle, on return.
- high to idle, on return.
- high-over-low back to low, on return.

Software reaches the flags, enables, level bits and control bits through a small register port with four addresses.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Address 0 holds the flags. A source pulse sets its flag and the flag stays set. A register write at address 0 ANDs the flags with the write data, so a 0 bit clears its flag and a 1 bit leaves it as it was. A pulse in the same cycle as a clearing write leaves the flag set.
- R2: In priority mode a source is taken only when its flag, its enable (address 1) and its level's global enable are all set and no service of equal or higher level is active. The take pulse lasts one cycle and comes two clock edges after the source pulse.
- R3: A high-level take reports vector 0x0008 and a low-level take reports 0x0018. In legacy mode every take reports 0x0008.
- R4: Control register (address 3): bit 0 turns on priority mode, bit 1 is the high-level global enable (the only global enable in legacy mode), and bit 2 is the low-level global enable (the peripheral-group enable in legacy mode). A take clears the enable bit of the level taken. A return sets the enable bit of the level that is ending.
- R5: While a high-level service is active, no low-level take occurs. A high-level request preempts an active low-level service. The return from that high-level service resumes the low-level service without a new take.
- R6: If both levels are eligible in the same cycle, the high level is taken. The low request stays pending and is taken after the high service returns.
- R7: In legacy mode, sources below `NUM_CORE` are gated only by control bit 1. Sources at or above `NUM_CORE` also need control bit 2.
- R8: The level bits are at address 2, where 1 means high. Source 0 is always high: its bit reads 1 and writes to it have no effect.
- R9: On every take, the three shadow outputs hold the context inputs as they stood in the cycle before the take pulse.
- R10: A high-level take over an active low-level service overwrites the shadow values saved by the low entry.
- R11: A return event while no service is active changes neither the control bits nor the service state.
- R12: After reset all flags, enables, level bits and control bits are 0, with the level bit of source 0 reading 1. No take is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NUM_SRC | One-cycle event pulse per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 flags, 1 enables, 2 levels, 3 control) |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data for reg_addr |
| ret_evt | input | 1 | Return-from-interrupt event |
| ctx_status | input | CTX_W | Live status byte |
| ctx_wreg | input | CTX_W | Live working register byte |
| ctx_bank | input | CTX_W | Live bank-select byte |
| irq_take | output | 1 | One-cycle take pulse |
| irq_vector | output | VEC_W | Target address of the latest take |
| shd_status | output | CTX_W | Shadowed status byte |
| shd_wreg | output | CTX_W | Shadowed working register byte |
| shd_bank | output | CTX_W | Shadowed bank-select byte |

## Verification
The bench targets the cases where level tracking goes wrong:
- **Preemption and resume.** A design that lost the preempted low service would take the low request a second time after the high return.
- **Same-cycle tie.** A design that compared levels wrongly would report 0x0018 first.
- **Gated peripheral source in legacy mode.** Ignoring the group enable would produce an early take.
- **Source 0.** Treating source 0 as programmable would send it to 0x0018.
- **Shadow overwrite.** Protecting the low-entry context from the nested high entry would leave stale shadow values.
- **Register writes.** Reading write-0 as "set" would show wrong flags on readback.
- **Return while idle.** Acting on a stray return in the idle state would set enables that software left clear.

// File: rtl/ic_pkg.sv
package ic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_HI_OVER_LO
    } ic_state_e;

    localparam logic [1:0] RA_FLAG = 2'd0;
    localparam logic [1:0] RA_EN   = 2'd1;
    localparam logic [1:0] RA_PRIO = 2'd2;
    localparam logic [1:0] RA_CTRL = 2'd3;

    localparam int CB_MODE = 0;
    localparam int CB_G1   = 1;
    localparam int CB_G2   = 2;

endpackage

// File: rtl/ic_flag_bank.sv
module ic_flag_bank
    import ic_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_CORE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] prio_q,
    output logic               hi_req,
    output logic               lo_req,
    output logic               core_req,
    output logic               peri_req
);

    logic [NUM_SRC-1:0] core_mask;
    logic [NUM_SRC-1:0] hot;
    logic               wr_flag, wr_en_reg, wr_prio;

    assign wr_flag   = wr_en && (wr_addr == RA_FLAG);
    assign wr_en_reg = wr_en && (wr_addr == RA_EN);
    assign wr_prio   = wr_en && (wr_addr == RA_PRIO);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else
                flag_q[g] <= (wr_flag ? (flag_q[g] & wr_data[g]) : flag_q[g]) | src_pulse[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[g] <= 1'b0;
            else if (wr_en_reg)
                en_q[g] <= wr_data[g];
        end

        if (g == 0) begin : g_fixed
            assign prio_q[g] = 1'b1;
        end else begin : g_prog
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    prio_q[g] <= 1'b0;
                else if (wr_prio)
                    prio_q[g] <= wr_data[g];
            end
        end

        assign core_mask[g] = (g < NUM_CORE);
    end

    assign hot      = flag_q & en_q;
    assign hi_req   = |(hot & prio_q);
    assign lo_req   = |(hot & ~prio_q);
    assign core_req = |(hot & core_mask);
    assign peri_req = |(hot & ~core_mask);

    // R1
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((flag_q & $past(src_pulse)) == $past(src_pulse)));

endmodule

// File: rtl/ic_shadow.sv
module ic_shadow #(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [CTX_W-1:0] st_in,
    input  logic [CTX_W-1:0] wr_in,
    input  logic [CTX_W-1:0] bk_in,
    output logic [CTX_W-1:0] st_q,
    output logic [CTX_W-1:0] wr_q,
    output logic [CTX_W-1:0] bk_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            wr_q <= '0;
            bk_q <= '0;
        end else if (cap) begin
            st_q <= st_in;
            wr_q <= wr_in;
            bk_q <= bk_in;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ic_pkg::*;
#(
    parameter int              NUM_SRC  = 8,
    parameter int              NUM_CORE = 4,
    parameter int              VEC_W    = 16,
    parameter int              CTX_W    = 8,
    parameter logic [VEC_W-1:0] VEC_HI  = 16'h0008,
    parameter logic [VEC_W-1:0] VEC_LO  = 16'h0018
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic               ret_evt,
    input  logic [CTX_W-1:0]   ctx_status,
    input  logic [CTX_W-1:0]   ctx_wreg,
    input  logic [CTX_W-1:0]   ctx_bank,
    output logic               irq_take,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [CTX_W-1:0]   shd_status,
    output logic [CTX_W-1:0]   shd_wreg,
    output logic [CTX_W-1:0]   shd_bank
);

    logic [NUM_SRC-1:0] flag_q, en_q, prio_q;
    logic               hi_req, lo_req, core_req, peri_req;
    logic               mode_q, g1_q, g2_q;
    logic               want_hi, want_lo, hi_active, ctrl_wr;
    ic_state_e          state_q, state_d;

    ic_flag_bank #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_flags (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q),
        .hi_req(hi_req), .lo_req(lo_req), .core_req(core_req), .peri_req(peri_req)
    );

    ic_shadow #(.CTX_W(CTX_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cap(want_hi | want_lo),
        .st_in(ctx_status), .wr_in(ctx_wreg), .bk_in(ctx_bank),
        .st_q(shd_status), .wr_q(shd_wreg), .bk_q(shd_bank)
    );

    assign hi_active = (state_q == ST_HI) || (state_q == ST_HI_OVER_LO);
    assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);

    // Arbitration: a return event blocks any take in the same cycle
    always_comb begin
        if (mode_q) begin
            want_hi = g1_q && hi_req && !hi_active && !ret_evt;
            want_lo = g2_q && lo_req && (state_q == ST_IDLE) && !want_hi && !ret_evt;
        end else begin
            want_hi = g1_q && (core_req || (g2_q && peri_req)) && !hi_active && !ret_evt;
            want_lo = 1'b0;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (want_hi)      state_d = ST_HI;
                else if (want_lo) state_d = ST_LO;
            end
            ST_LO: begin
                if (ret_evt)      state_d = ST_IDLE;
                else if (want_hi) state_d = ST_HI_OVER_LO;
            end
            ST_HI: begin
                if (ret_evt)      state_d = ST_IDLE;
            end
            ST_HI_OVER_LO: begin
                if (ret_evt)      state_d = ST_LO;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Control bits: software write first, take/return override
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            g1_q   <= 1'b0;
            g2_q   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                mode_q <= reg_wdata[CB_MODE];
                g1_q   <= reg_wdata[CB_G1];
                g2_q   <= reg_wdata[CB_G2];
            end
            if (want_hi) g1_q <= 1'b0;
            if (want_lo) g2_q <= 1'b0;
            if (ret_evt) begin
                unique case (state_q)
                    ST_IDLE:       ;
                    ST_LO:         g2_q <= 1'b1;
                    ST_HI:         g1_q <= 1'b1;
                    ST_HI_OVER_LO: g1_q <= 1'b1;
                endcase
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_take   <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_take <= want_hi | want_lo;
            if (want_hi)      irq_vector <= VEC_HI;
            else if (want_lo) irq_vector <= VEC_LO;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_FLAG: reg_rdata = flag_q;
            RA_EN:   reg_rdata = en_q;
            RA_PRIO: reg_rdata = prio_q;
            RA_CTRL: begin
                reg_rdata[CB_MODE] = mode_q;
                reg_rdata[CB_G1]   = g1_q;
                reg_rdata[CB_G2]   = g2_q;
            end
        endcase
    end

    // R3
    legacy_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !$past(mode_q)) |-> (irq_vector == VEC_HI));

    // R4
    lo_gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vector == VEC_LO) |-> !g2_q);

    // R4
    hi_gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vector == VEC_HI) |-> !g1_q);

    // R5
    lo_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vector == VEC_LO) |-> (state_q == ST_LO));

    // R9
    shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (shd_status == $past(ctx_status) && shd_wreg == $past(ctx_wreg)
                      && shd_bank == $past(ctx_bank)));

    // R11
    idle_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ret_evt) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_pulse = '0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         ret_evt = 1'b0;
    logic [7:0]   ctx_status = '0, ctx_wreg = '0, ctx_bank = '0;
    logic         irq_take;
    logic [15:0]  irq_vector;
    logic [7:0]   shd_status, shd_wreg, shd_bank;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ret_evt(ret_evt), .ctx_status(ctx_status), .ctx_wreg(ctx_wreg), .ctx_bank(ctx_bank),
        .irq_take(irq_take), .irq_vector(irq_vector),
        .shd_status(shd_status), .shd_wreg(shd_wreg), .shd_bank(shd_bank)
    );

    always #10 clk = ~clk;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int n_take = 0, last_vec = 0;
    int p_st = 0, p_wr = 0, p_bk = 0;

    // reference model state
    int m_flag, m_en, m_prio, m_mode, m_g1, m_g2, m_state;
    int m_take, m_vec, m_sst, m_swr, m_sbk;
    int hot, hact, th, tl, nstate;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        #5;
        ctx_status = cyc[7:0];
        ctx_wreg   = cyc[7:0] ^ 8'h5A;
        ctx_bank   = cyc[7:0] + 8'd3;
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_en = 0; m_prio = 0; m_mode = 0; m_g1 = 0; m_g2 = 0;
            m_state = 0; m_take = 0; m_vec = 0; m_sst = 0; m_swr = 0; m_sbk = 0;
        end else begin
            hot  = m_flag & m_en;
            hact = (m_state == 2 || m_state == 3);
            if (m_mode != 0) begin
                th = (m_g1 != 0 && (hot & (m_prio | 1)) != 0 && !hact);
                tl = (m_g2 != 0 && (hot & ~(m_prio | 1) & 8'hFF) != 0 && m_state == 0 && !th);
            end else begin
                th = (m_g1 != 0 && ((hot & 8'h0F) != 0 || (m_g2 != 0 && (hot & 8'hF0) != 0)) && !hact);
                tl = 0;
            end
            if (ret_evt) begin th = 0; tl = 0; end
            if (reg_wr && reg_addr == 0) m_flag = m_flag & reg_wdata;
            m_flag = m_flag | src_pulse;
            if (reg_wr && reg_addr == 1) m_en = reg_wdata;
            if (reg_wr && reg_addr == 2) m_prio = reg_wdata & 8'hFE;
            if (reg_wr && reg_addr == 3) begin
                m_mode = reg_wdata[0]; m_g1 = reg_wdata[1]; m_g2 = reg_wdata[2];
            end
            if (th != 0) m_g1 = 0;
            if (tl != 0) m_g2 = 0;
            nstate = m_state;
            if (ret_evt) begin
                if (m_state == 1) begin m_g2 = 1; nstate = 0; end
                else if (m_state == 2) begin m_g1 = 1; nstate = 0; end
                else if (m_state == 3) begin m_g1 = 1; nstate = 1; end
            end else if (th != 0) nstate = (m_state == 1) ? 3 : 2;
            else if (tl != 0) nstate = 1;
            m_state = nstate;
            m_take = th | tl;
            if (m_take != 0) begin
                m_vec = (th != 0) ? 8 : 24;
                m_sst = ctx_status; m_swr = ctx_wreg; m_sbk = ctx_bank;
            end
        end
    end

    function automatic int m_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_flag;
            2'd1: return m_en;
            2'd2: return m_prio | 1;
            default: return m_mode | (m_g1 << 1) | (m_g2 << 2);
        endcase
    endfunction

    // per-cycle comparison against the model, plus take monitor
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (irq_take != m_take[0] || irq_vector != m_vec[15:0]) begin
                n_bad++;
                $display("FAIL R3 take/vector actual=%0h/%0h expected=%0h/%0h",
                         irq_take, irq_vector, m_take, m_vec);
            end else if (shd_status != m_sst[7:0] || shd_wreg != m_swr[7:0] || shd_bank != m_sbk[7:0]) begin
                n_bad++;
                $display("FAIL R9 shadow actual=%0h expected=%0h", shd_status, m_sst);
            end else if (reg_rdata != m_rd(reg_addr)) begin
                n_bad++;
                $display("FAIL R1 readback actual=%0h expected=%0h", reg_rdata, m_rd(reg_addr));
            end
            if (irq_take) begin
                n_take++;
                last_vec = irq_vector;
                chk("R9 shadow at take", {shd_status, shd_wreg, shd_bank}, {p_st[7:0], p_wr[7:0], p_bk[7:0]});
            end
        end
        p_st = ctx_status; p_wr = ctx_wreg; p_bk = ctx_bank;
    end

    task automatic wr(input logic [1:0] a, input int d);
        @(posedge clk); #5;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d[N-1:0];
        @(posedge clk); #5;
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int m);
        @(posedge clk); #5;
        src_pulse = m[N-1:0];
        @(posedge clk); #5;
        src_pulse = '0;
    endtask

    task automatic ret;
        @(posedge clk); #5;
        ret_evt = 1'b1;
        @(posedge clk); #5;
        ret_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(posedge clk); #5;
        reg_addr = a;
        @(negedge clk); #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int v, t0, s0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;

        // R12 reset state
        rd(2'd0, v); chk("R12 flags", v, 0);
        rd(2'd1, v); chk("R12 enables", v, 0);
        rd(2'd2, v); chk("R12 levels", v, 1);
        rd(2'd3, v); chk("R12 control", v, 0);
        chk("R12 no take", n_take, 0);

        // legacy core source
        wr(2'd1, 8'h22);
        wr(2'd3, 3'b010);
        t0 = n_take;
        pulse(8'h02); idle(3);
        chk("R7 legacy core take", n_take, t0 + 1);
        chk("R3 legacy vector", last_vec, 16'h0008);
        rd(2'd3, v); chk("R4 enable cleared", v, 0);
        rd(2'd0, v); chk("R1 flag sticky", v, 8'h02);
        wr(2'd0, 8'hFD);
        rd(2'd0, v); chk("R1 write-0 clears", v, 0);
        ret;
        rd(2'd3, v); chk("R4 return restores", v, 3'b010);

        // legacy peripheral source gated by group enable
        t0 = n_take;
        pulse(8'h20); idle(4);
        chk("R7 peripheral gated", n_take, t0);
        wr(2'd3, 3'b110); idle(3);
        chk("R7 peripheral taken", n_take, t0 + 1);
        chk("R3 peripheral vector", last_vec, 16'h0008);
        wr(2'd0, 0);
        ret;
        rd(2'd3, v); chk("R4 legacy restore", v, 3'b110);
        ret;
        rd(2'd3, v); chk("R11 idle return", v, 3'b110);

        // priority mode
        wr(2'd1, 8'h0D);
        wr(2'd2, 8'h08);
        rd(2'd2, v); chk("R8 level readback", v, 8'h09);
        wr(2'd3, 3'b111);
        t0 = n_take;
        pulse(8'h04); idle(3);
        chk("R2 low take", n_take, t0 + 1);
        chk("R3 low vector", last_vec, 16'h0018);
        s0 = shd_status;
        rd(2'd3, v); chk("R4 low enable cleared", v, 3'b011);
        pulse(8'h08); idle(3);
        chk("R5 preempt take", n_take, t0 + 2);
        chk("R5 preempt vector", last_vec, 16'h0008);
        chk("R10 shadow overwritten", (shd_status != s0) ? 1 : 0, 1);
        wr(2'd0, 8'hF7);
        ret; idle(3);
        chk("R5 resume without take", n_take, t0 + 2);
        rd(2'd3, v); chk("R4 high restore", v, 3'b011);
        wr(2'd0, 8'hFB);
        ret;
        rd(2'd3, v); chk("R4 low restore", v, 3'b111);

        // same-cycle tie
        t0 = n_take;
        pulse(8'h0C); idle(3);
        chk("R6 tie count", n_take, t0 + 1);
        chk("R6 high wins", last_vec, 16'h0008);
        wr(2'd0, 8'hF7);
        ret; idle(3);
        chk("R6 low later", n_take, t0 + 2);
        chk("R6 low vector", last_vec, 16'h0018);
        wr(2'd0, 8'hFB);
        ret;

        // low held off during high
        t0 = n_take;
        pulse(8'h08); idle(2);
        pulse(8'h04); idle(4);
        chk("R5 low held", n_take, t0 + 1);
        wr(2'd0, 8'hF7);
        ret; idle(3);
        chk("R5 low after high", last_vec, 16'h0018);
        wr(2'd0, 8'hFB);
        ret;

        // source 0 fixed high
        wr(2'd2, 0);
        rd(2'd2, v); chk("R8 fixed level bit", v, 1);
        pulse(8'h01); idle(3);
        chk("R8 source0 high", last_vec, 16'h0008);
        wr(2'd0, 8'hFE);
        ret;

        // write-1 and pulse during clear
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R1 write-1 keeps", v, 0);
        @(posedge clk); #5;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = '0; src_pulse = 8'h40;
        @(posedge clk); #5;
        reg_wr = 1'b0; src_pulse = '0;
        rd(2'd0, v); chk("R1 pulse beats clear", v, 8'h40);
        idle(4);
        summary();
    end

endmodule